// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block holds the current second, minute, hour, weekday, day of month, month and two-digit year as bytes in a small register file. A separate time base supplies a one-cycle pulse once per second, and each pulse advances the whole date and time by one second. Every carry is handled in the same update: seconds into minutes, minutes into hours, hours into days, days into months by month length, and months into years.

Software reaches the block through a byte-wide register port. The read path is combinational on the address. A read strobe marks the reads that have side effects. A mode register selects BCD or plain binary numbers and 12-hour or 24-hour hours. The mode can change at run time. The stored bytes are kept as written, and each update decodes, counts and re-encodes them in the current mode.

A freeze bit lets software load a new time without the counter racing it. An update-in-progress flag opens a fixed number of cycles before the bytes change and closes a fixed number of cycles after. Software that sees the flag clear can read a consistent set of bytes. An update-ended flag records that an update has completed. A status byte reports the backup-power input.

Top module: `caltime_core`

## Requirements
- R1: The time bytes sit at these offsets: seconds 0, minutes 2, hours 4, weekday 6, day of month 7, month 8, year 9. A written value reads back unchanged. Offsets 1, 3, 5 and 13 ignore writes and read 0x00.
- R2: In BCD mode each update adds one second. Seconds 0x09 become 0x10. Seconds 0x59 become 0x00 and add one minute. Minutes 0x59 become 0x00 and add one hour.
- R3: Register 11 bit 2 set selects binary mode. In binary mode every field counts in plain binary: seconds 0x09 become 0x0A, seconds 0x3B wrap to 0x00, and the year wraps from 0x63 to 0x00.
- R4: Register 11 bit 1 set selects 24-hour mode, where hour 23 wraps to 0 and adds a day. When the bit is clear, hours run 1 to 12 with hours bit 7 set for PM, in this order: 11 AM, 12 PM, 1 PM, …, 11 PM, 12 AM. The wrap from 11 PM to 12 AM adds a day.
- R5: While register 11 bit 7 (freeze) is set, no update takes place. A second pulse that arrives during freeze is discarded and does not take effect after freeze is cleared.
- R6: Register 10 bit 7 (update in progress) rises in the cycle after an accepted pulse. It stays high for LEAD_CYC cycles before the time bytes change and for HOLD_CYC cycles after. Pulses that arrive while it is high are ignored.
- R7: Weekday 7 wraps to 1. Day of month wraps to 1 after the last day of the month: 28 for February, or 29 when the year is a multiple of 4; 30 for months 4, 6, 9 and 11; 31 for all other months. Month 12 wraps to 1 and adds a year. Year 99 wraps to 0.
- R8: Register 12 bit 4 (update ended) is set in the same cycle that update in progress falls.
- R9: A strobed read of register 12 returns the flag's current value and then clears the flag. If an update ends in the same cycle, the flag stays set.
- R10: Register 14 reads 0x80 when the backup-power input is high and 0x00 when it is low. Register 10 reads 0x00 while no update is in progress. Register 11 keeps only bits 7, 2 and 1 and reads 0 in all other bits.
- R11: After reset the time is 12 AM, second 0, weekday 1, day 1, month 1, year 0. Register 11 and the update-ended flag are 0, so the block starts in BCD, 12-hour mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle once-per-second pulse from the time base |
| batt_ok | input | 1 | Backup power good, reported in register 14 |
| reg_addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (clears the update-ended flag on offset 12) |
| rd_data | output | 8 | Read data for reg_addr, combinational |

## Verification
The stimulus table aims at the carries that a small slip gets wrong. A design that compares against the wrong day count would give February 29 in a year that is not a leap year, or skip it in one that is. A design that confuses 12 PM with 12 AM would move the day at noon, or set the PM bit at midnight. A design that adds in binary while BCD is selected would turn 0x09 into 0x0A. Directed tests count the cycles of the update-in-progress window on both sides of the update, since a window that opens late lets software read a half-changed time. They also check that a pulse arriving during freeze is not replayed afterwards and that a second pulse inside the window does not add a second count. Finally they check that reading the update-ended flag clears it only after the value has been returned.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t wday;
        byte_t mday;
        byte_t mon;
        byte_t year;
    } cal_t;

    typedef struct packed {
        logic freeze;
        logic binary;
        logic h24;
    } mode_t;

    typedef enum logic [1:0] {SQ_IDLE, SQ_LEAD, SQ_HOLD} seq_state_e;

    localparam int OFS_SEC  = 0;
    localparam int OFS_MIN  = 2;
    localparam int OFS_HOUR = 4;
    localparam int OFS_WDAY = 6;
    localparam int OFS_MDAY = 7;
    localparam int OFS_MON  = 8;
    localparam int OFS_YEAR = 9;
    localparam int OFS_STAT = 10;
    localparam int OFS_MODE = 11;
    localparam int OFS_FLAG = 12;
    localparam int OFS_PWR  = 14;

    localparam int FREEZE_BIT = 7;
    localparam int BIN_BIT    = 2;
    localparam int H24_BIT    = 1;

    localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h12,
                                   wday: 8'h01, mday: 8'h01, mon: 8'h01,
                                   year: 8'h00};

    function automatic byte_t to_bin(byte_t v, logic binary);
        byte_t tens;
        tens = {4'd0, v[7:4]};
        return binary ? v : byte_t'(tens * 8'd10 + {4'd0, v[3:0]});
    endfunction

    function automatic byte_t from_bin(byte_t v, logic binary);
        byte_t t;
        byte_t u;
        t = v / 8'd10;
        u = v % 8'd10;
        return binary ? v : {t[3:0], u[3:0]};
    endfunction

    function automatic byte_t month_days(byte_t mon, byte_t yr);
        byte_t d;
        case (mon)
            8'd2:                    d = ((yr % 8'd4) == 8'd0) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: d = 8'd30;
            default:                 d = 8'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/caltime_seq.sv
module caltime_seq
    import caltime_pkg::*;
#(
    parameter int LEAD_CYC = 4,
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic freeze,
    output logic uip,
    output logic apply,
    output logic done
);
    localparam int MAX_CYC = (LEAD_CYC > HOLD_CYC) ? LEAD_CYC : HOLD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (tick && !freeze) begin
                    state_q <= SQ_LEAD;
                    cnt_q   <= CNT_W'(LEAD_CYC - 1);
                end
                SQ_LEAD: begin
                    if (freeze) begin
                        state_q <= SQ_IDLE;
                        cnt_q   <= '0;
                    end else if (cnt_q == '0) begin
                        state_q <= SQ_HOLD;
                        cnt_q   <= CNT_W'(HOLD_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                SQ_HOLD: begin
                    if (cnt_q == '0) state_q <= SQ_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign uip   = (state_q != SQ_IDLE);
    assign apply = (state_q == SQ_LEAD) && (cnt_q == '0) && !freeze;
    assign done  = (state_q == SQ_HOLD) && (cnt_q == '0);

    // R5: a pulse seen while frozen opens no window
    p_drop_frozen_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_IDLE && tick && freeze) |=> !uip);

    // R6: the window closes right after it ends
    p_window_closes_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !uip);

endmodule

// File: rtl/caltime_advance.sv
module caltime_advance
    import caltime_pkg::*;
(
    input  cal_t cur,
    input  logic binary,
    input  logic h24,
    output cal_t nxt
);
    byte_t s, m, h, h12, wd, md, mo, yr;
    byte_t s_n, m_n, h_n, wd_n, md_n, mo_n, yr_n;
    logic  c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        s   = to_bin(cur.sec, binary);
        m   = to_bin(cur.min, binary);
        wd  = to_bin(cur.wday, binary);
        md  = to_bin(cur.mday, binary);
        mo  = to_bin(cur.mon, binary);
        yr  = to_bin(cur.year, binary);
        h12 = to_bin({1'b0, cur.hour[6:0]}, binary);
        if (h24)                h = to_bin(cur.hour, binary);
        else if (h12 == 8'd12) h = cur.hour[7] ? 8'd12 : 8'd0;
        else                    h = cur.hour[7] ? h12 + 8'd12 : h12;

        c_min = (s >= 8'd59);
        c_hr  = c_min && (m >= 8'd59);
        c_day = c_hr  && (h >= 8'd23);
        c_mon = c_day && (md >= month_days(mo, yr));
        c_yr  = c_mon && (mo >= 8'd12);

        s_n  = c_min ? 8'd0 : s + 8'd1;
        m_n  = c_hr  ? 8'd0 : (c_min ? m + 8'd1 : m);
        h_n  = c_day ? 8'd0 : (c_hr ? h + 8'd1 : h);
        wd_n = c_day ? ((wd >= 8'd7) ? 8'd1 : wd + 8'd1) : wd;
        md_n = c_mon ? 8'd1 : (c_day ? md + 8'd1 : md);
        mo_n = c_yr  ? 8'd1 : (c_mon ? mo + 8'd1 : mo);
        yr_n = c_yr  ? ((yr >= 8'd99) ? 8'd0 : yr + 8'd1) : yr;

        nxt.sec  = from_bin(s_n, binary);
        nxt.min  = from_bin(m_n, binary);
        nxt.wday = from_bin(wd_n, binary);
        nxt.mday = from_bin(md_n, binary);
        nxt.mon  = from_bin(mo_n, binary);
        nxt.year = from_bin(yr_n, binary);
        if (h24)                nxt.hour = from_bin(h_n, binary);
        else if (h_n == 8'd0)  nxt.hour = from_bin(8'd12, binary);
        else if (h_n < 8'd12)  nxt.hour = from_bin(h_n, binary);
        else if (h_n == 8'd12) nxt.hour = from_bin(8'd12, binary) | 8'h80;
        else                    nxt.hour = from_bin(h_n - 8'd12, binary) | 8'h80;
    end

endmodule

// File: rtl/caltime_core.sv
module caltime_core
    import caltime_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int LEAD_CYC = 4,
    parameter int HOLD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              batt_ok,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data
);
    cal_t  time_q;
    cal_t  time_nxt;
    mode_t mode_q;
    logic  uf_q;
    logic  uip_w, apply_w, done_w;

    function automatic logic at(logic [ADDR_W-1:0] a, int ofs);
        return a == ADDR_W'(ofs);
    endfunction

    caltime_seq #(.LEAD_CYC(LEAD_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .tick   (sec_tick),
        .freeze (mode_q.freeze),
        .uip    (uip_w),
        .apply  (apply_w),
        .done   (done_w)
    );

    caltime_advance u_adv (
        .cur    (time_q),
        .binary (mode_q.binary),
        .h24    (mode_q.h24),
        .nxt    (time_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= CAL_RESET;
            mode_q <= '0;
            uf_q   <= 1'b0;
        end else begin
            if (apply_w) time_q <= time_nxt;
            if (wr_en) begin
                if (at(reg_addr, OFS_SEC))  time_q.sec  <= wr_data;
                if (at(reg_addr, OFS_MIN))  time_q.min  <= wr_data;
                if (at(reg_addr, OFS_HOUR)) time_q.hour <= wr_data;
                if (at(reg_addr, OFS_WDAY)) time_q.wday <= wr_data;
                if (at(reg_addr, OFS_MDAY)) time_q.mday <= wr_data;
                if (at(reg_addr, OFS_MON))  time_q.mon  <= wr_data;
                if (at(reg_addr, OFS_YEAR)) time_q.year <= wr_data;
                if (at(reg_addr, OFS_MODE)) begin
                    mode_q.freeze <= wr_data[FREEZE_BIT];
                    mode_q.binary <= wr_data[BIN_BIT];
                    mode_q.h24    <= wr_data[H24_BIT];
                end
            end
            if (done_w)                                uf_q <= 1'b1;
            else if (rd_en && at(reg_addr, OFS_FLAG)) uf_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (at(reg_addr, OFS_SEC))  rd_data = time_q.sec;
        if (at(reg_addr, OFS_MIN))  rd_data = time_q.min;
        if (at(reg_addr, OFS_HOUR)) rd_data = time_q.hour;
        if (at(reg_addr, OFS_WDAY)) rd_data = time_q.wday;
        if (at(reg_addr, OFS_MDAY)) rd_data = time_q.mday;
        if (at(reg_addr, OFS_MON))  rd_data = time_q.mon;
        if (at(reg_addr, OFS_YEAR)) rd_data = time_q.year;
        if (at(reg_addr, OFS_STAT)) rd_data = {uip_w, 7'd0};
        if (at(reg_addr, OFS_MODE)) rd_data = {mode_q.freeze, 4'd0, mode_q.binary, mode_q.h24, 1'b0};
        if (at(reg_addr, OFS_FLAG)) rd_data = {3'd0, uf_q, 4'd0};
        if (at(reg_addr, OFS_PWR))  rd_data = {batt_ok, 7'd0};
    end

    // R5: frozen time only changes through software writes
    p_freeze_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_q.freeze && !wr_en) |=> $stable(time_q));

    // R6: counting changes happen only inside the busy window
    p_update_in_window_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && (time_q != $past(time_q))) |-> $past(uip_w));

    // R8: end of update raises the flag
    p_uf_set_r8: assert property (@(posedge clk) disable iff (rst)
        done_w |=> uf_q);

    // R9: strobed read clears the flag unless an update ends at once
    p_uf_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && at(reg_addr, OFS_FLAG) && !done_w) |=> !uf_q);

endmodule

// File: tb/sim_caltime_core.sv
module sim_caltime_core;

    localparam int LEAD = 4;
    localparam int HOLD = 2;
    localparam int NVEC = 16;

    // {req, mode, sec min hour wday mday mon year, expected sec..year}
    localparam logic [127:0] VEC [NVEC] = '{
        128'h02_02_05000001010100_06000001010100,
        128'h02_02_59592203100524_00002303100524,
        128'h07_02_59592307311299_00000001010100,
        128'h07_02_59592303280224_00000004290224,
        128'h07_02_59592303280223_00000004010323,
        128'h07_02_59592304290224_00000005010324,
        128'h07_02_59592305300421_00000006010521,
        128'h07_02_59592306300121_00000007310121,
        128'h03_06_3B3B17071F0C63_00000001010100,
        128'h03_06_090005020A0314_0A0005020A0314,
        128'h04_00_59591102050622_00009202050622,
        128'h04_00_59599202050622_00008102050622,
        128'h04_00_59599107150622_00001201160622,
        128'h04_00_59591202050622_00000102050622,
        128'h04_04_3B3B8B02050616_00000C03060616,
        128'h02_02_09291002050622_10291002050622
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       batt_ok = 1'b1;
    logic [3:0] reg_addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    caltime_core #(.ADDR_W(4), .LEAD_CYC(LEAD), .HOLD_CYC(HOLD)) u0 (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .batt_ok(batt_ok),
        .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = 4'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = 4'(a); rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic read_time(output logic [55:0] t);
        logic [7:0] b [7];
        rd(0, b[0]); rd(2, b[1]); rd(4, b[2]); rd(6, b[3]);
        rd(7, b[4]); rd(8, b[5]); rd(9, b[6]);
        t = {b[0], b[1], b[2], b[3], b[4], b[5], b[6]};
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [55:0] t;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        read_time(t);
        chk("R11 reset time", 64'(t), 64'h00_00_12_01_01_01_00);
        rd(11, d); chk("R11 reset mode", 64'(d), 64'h00);
        rd(12, d); chk("R11 reset flag", 64'(d), 64'h00);
        rd(10, d); chk("R10 status idle", 64'(d), 64'h00);

        // R10: power status and mode bits
        rd(14, d); chk("R10 power good", 64'(d), 64'h80);
        batt_ok = 1'b0;
        rd(14, d); chk("R10 power lost", 64'(d), 64'h00);
        batt_ok = 1'b1;
        wr(11, 8'hFF);
        rd(11, d); chk("R10 mode bits", 64'(d), 64'h86);

        // R1: read-back and unused offsets
        wr(0, 8'h37); rd(0, d); chk("R1 sec readback", 64'(d), 64'h37);
        wr(3, 8'hAA); rd(3, d); chk("R1 offset 3", 64'(d), 64'h00);
        wr(1, 8'h55); rd(1, d); chk("R1 offset 1", 64'(d), 64'h00);
        wr(5, 8'h5A); rd(5, d); chk("R1 offset 5", 64'(d), 64'h00);
        wr(13, 8'hC3); rd(13, d); chk("R1 offset 13", 64'(d), 64'h00);

        // table walk: R2 R3 R4 R7
        for (int i = 0; i < NVEC; i++) begin
            logic [127:0] v;
            v = VEC[i];
            wr(11, v[119:112] | 8'h80);
            wr(0, v[111:104]); wr(2, v[103:96]); wr(4, v[95:88]);
            wr(6, v[87:80]);   wr(7, v[79:72]);  wr(8, v[71:64]);
            wr(9, v[63:56]);
            wr(11, v[119:112]);
            pulse();
            repeat (LEAD + HOLD + 2) @(negedge clk);
            read_time(t);
            chk($sformatf("R%0d vector %0d", v[127:120], i), 64'(t), 64'(v[55:0]));
        end
        rd(12, d);

        // R6: window timing around one update
        wr(11, 8'h82); wr(0, 8'h20); wr(11, 8'h02);
        @(negedge clk); sec_tick = 1'b1; reg_addr = 4'd10;
        @(negedge clk); sec_tick = 1'b0;
        #1 chk("R6 busy after pulse", 64'(rd_data), 64'h80);
        repeat (LEAD - 1) @(negedge clk);
        reg_addr = 4'd0;
        #1 chk("R6 old value in lead", 64'(rd_data), 64'h20);
        @(negedge clk);
        #1 chk("R6 new value", 64'(rd_data), 64'h21);
        reg_addr = 4'd10;
        #1 chk("R6 busy in hold", 64'(rd_data), 64'h80);
        repeat (HOLD) @(negedge clk);
        #1 chk("R6 busy cleared", 64'(rd_data), 64'h00);
        reg_addr = 4'd12;
        #1 chk("R8 flag set", 64'(rd_data), 64'h10);

        // R9: read returns then clears
        rd(12, d); chk("R9 first read", 64'(d), 64'h10);
        rd(12, d); chk("R9 second read", 64'(d), 64'h00);

        // R6: second pulse inside window is ignored
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (LEAD + HOLD + 4) @(negedge clk);
        rd(0, d); chk("R6 one count per window", 64'(d), 64'h22);

        // R5: frozen pulse dropped and not replayed
        wr(11, 8'h82); wr(0, 8'h40);
        @(negedge clk); sec_tick = 1'b1; reg_addr = 4'd10;
        @(negedge clk); sec_tick = 1'b0;
        #1 chk("R5 no busy while frozen", 64'(rd_data), 64'h00);
        repeat (10) @(negedge clk);
        rd(0, d); chk("R5 frozen sec", 64'(d), 64'h40);
        wr(11, 8'h02);
        repeat (10) @(negedge clk);
        rd(0, d); chk("R5 no replay", 64'(d), 64'h40);

        summary();
        $finish;
    end

endmodule